// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between a handheld console's 16-bit cartridge bus and a larger external ROM and RAM. It turns every bus address into the upper ROM address lines and the RAM bank lines, and it drives the chip enables of both memories. The ROM range cannot be written, so a write into it never reaches the memory. The block decodes such a write instead and loads one of four control values: a RAM-enable key, the low ROM bank, a two-bit upper value, and a banking mode.

The two banking modes trade ROM reach against RAM reach. In mode 0 the two-bit upper value extends the ROM bank to seven bits, which covers 16 Mbit of ROM with a single 8 KB RAM page. In mode 1 the same two bits select one of four 8 KB RAM pages (32 KB in all), and the ROM is limited to 32 banks (4 Mbit). On the bus the top address line settles later than the others. For that reason the block commits a write only when the write strobe is released, and it uses the address and data it saw in the last cycle the strobe was low.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the low ROM bank is 1, the upper value is 0, the mode is 0 and RAM is disabled. A read at 0x4000 therefore gives `rom_bank` = 1, and `ram_ce_n` stays high.
- R2: When bus address bits 15:14 are 00, `rom_bank` is 0 in both modes and for any register contents.
- R3: In mode 0, an address with bits 15:14 = 01 gives `rom_bank` = {upper value, low bank}, with the upper value on bits 6:5. In mode 0 `ram_bank` is 0.
- R4: A write to 0x2000–0x3FFF loads data bits 4:0 as the low bank. If those five bits are 0, the low bank becomes 1, so 0x00 and 0x20 both select bank 1.
- R5: A write to 0x0000–0x1FFF enables RAM when data bits 3:0 are 0xA, whatever the upper nibble holds. Any other low nibble disables RAM.
- R6: A write to 0x4000–0x5FFF loads data bits 1:0 as the upper value. A write to 0x6000–0x7FFF sets the mode from data bit 0. In mode 1, `rom_bank` bits 6:5 are 0 for the upper window and `ram_bank` equals the upper value.
- R7: `ram_ce_n` is low only when RAM is enabled, `ram_cs_n` is low and the address lies in 0xA000–0xBFFF.
- R8: `rom_ce_n` is low exactly when `rd_n` is low and address bit 15 is 0.
- R9: A write commits at the first clock edge that sees `wr_n` high after one or more edges that saw it low. It uses the address and data of the last edge that saw `wr_n` low. If address bit 15 was 1 at that edge, the write changes no register, whatever address was present earlier in the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, faster than the bus strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Cartridge bus address |
| bus_data | input | 8 | Cartridge bus write data |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ram_cs_n | input | 1 | External RAM window select, active low |
| rom_bank | output | 7 | ROM address lines A20:A14 |
| ram_bank | output | 2 | RAM address lines A14:A13 |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |

## Verification
Two things can fall in the same clock edge: a register commit and an address translation that the new register value changes. The bench releases a mode-1 write strobe while the bus already shows a RAM-window address with `ram_cs_n` low. It checks `ram_bank` just before that edge, where the old mode must still apply, and just after it, where the new mode must apply. It also checks that the RAM-window address present at the release is not taken as the write address. A second case moves address bit 15 in the middle of a strobe, in both directions. It shows that only the address at the last low-strobe edge decides whether the write counts.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  localparam int unsigned ROM_LO_W = 5;
  localparam int unsigned UPPER_W  = 2;
  localparam int unsigned ROM_W    = ROM_LO_W + UPPER_W;
  localparam logic [3:0]  RAM_KEY  = 4'hA;

  typedef enum logic [1:0] {
    SEL_RAMEN = 2'b00,
    SEL_LOBNK = 2'b01,
    SEL_UPPER = 2'b10,
    SEL_MODE  = 2'b11
  } ctl_sel_e;
endpackage

// File: rtl/cart_wr_capture.sv
module cart_wr_capture #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:13]      addr_hi,
  input  logic [DATA_W-1:0] data,
  input  logic              wr_n,
  output logic              commit,
  output logic [1:0]        commit_sel,
  output logic [DATA_W-1:0] commit_data
);
  logic              wr_low_q;
  logic [15:13]      a_q, a_d;
  logic [DATA_W-1:0] d_q, d_d;
  logic              cap_en;

  assign cap_en = ~wr_n;

  always_comb begin
    a_d = a_q;
    d_d = d_q;
    if (cap_en) begin
      a_d = addr_hi;
      d_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_low_q <= 1'b0;
      a_q      <= '0;
      d_q      <= '0;
    end else begin
      wr_low_q <= cap_en;
      a_q      <= a_d;
      d_q      <= d_d;
    end
  end

  assign commit      = wr_low_q & wr_n & ~a_q[15];
  assign commit_sel  = a_q[14:13];
  assign commit_data = d_q;
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [1:0]          commit_sel,
  input  logic [DATA_W-1:0]   commit_data,
  output logic [ROM_LO_W-1:0] lo_bank,
  output logic [UPPER_W-1:0]  upper,
  output logic                mode,
  output logic                ram_en
);
  logic [ROM_LO_W-1:0] lo_d;
  logic [UPPER_W-1:0]  up_d;
  logic                mode_d, en_d;
  logic [ROM_LO_W-1:0] lo_raw;

  assign lo_raw = commit_data[ROM_LO_W-1:0];

  always_comb begin
    lo_d   = lo_bank;
    up_d   = upper;
    mode_d = mode;
    en_d   = ram_en;
    if (commit) begin
      unique case (ctl_sel_e'(commit_sel))
        SEL_RAMEN: en_d   = (commit_data[3:0] == RAM_KEY);
        SEL_LOBNK: lo_d   = (lo_raw == '0) ? ROM_LO_W'(1) : lo_raw;
        SEL_UPPER: up_d   = commit_data[UPPER_W-1:0];
        SEL_MODE:  mode_d = commit_data[0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_bank <= ROM_LO_W'(1);
      upper   <= '0;
      mode    <= 1'b0;
      ram_en  <= 1'b0;
    end else if (commit) begin
      lo_bank <= lo_d;
      upper   <= up_d;
      mode    <= mode_d;
      ram_en  <= en_d;
    end
  end
endmodule

// File: rtl/cart_addr_map.sv
module cart_addr_map
  import cart_bank_pkg::*;
(
  input  logic [15:13]        addr_hi,
  input  logic                rd_n,
  input  logic                ram_cs_n,
  input  logic [ROM_LO_W-1:0] lo_bank,
  input  logic [UPPER_W-1:0]  upper,
  input  logic                mode,
  input  logic                ram_en,
  output logic [ROM_W-1:0]    rom_bank,
  output logic [UPPER_W-1:0]  ram_bank,
  output logic                rom_ce_n,
  output logic                ram_ce_n
);
  logic [UPPER_W-1:0] rom_top;

  assign rom_top = mode ? '0 : upper;

  always_comb begin
    if (addr_hi[14]) rom_bank = {rom_top, lo_bank};
    else             rom_bank = '0;
  end

  assign ram_bank = mode ? upper : '0;
  assign rom_ce_n = ~(~rd_n & ~addr_hi[15]);
  assign ram_ce_n = ~(ram_en & ~ram_cs_n & (addr_hi == 3'b101));
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      bus_addr,
  input  logic [7:0]       bus_data,
  input  logic             rd_n,
  input  logic             wr_n,
  input  logic             ram_cs_n,
  output logic [ROM_W-1:0] rom_bank,
  output logic [UPPER_W-1:0] ram_bank,
  output logic             rom_ce_n,
  output logic             ram_ce_n
);
  logic [1:0] rst_sync;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  logic                commit;
  logic [1:0]          commit_sel;
  logic [7:0]          commit_data;
  logic [ROM_LO_W-1:0] lo_bank;
  logic [UPPER_W-1:0]  upper;
  logic                mode;
  logic                ram_en;

  cart_wr_capture #(.DATA_W(8)) u_cap (
    .clk(clk), .rst_n(rst_int_n), .addr_hi(bus_addr[15:13]), .data(bus_data),
    .wr_n(wr_n), .commit(commit), .commit_sel(commit_sel), .commit_data(commit_data)
  );

  cart_bank_regs #(.DATA_W(8)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .commit(commit), .commit_sel(commit_sel),
    .commit_data(commit_data), .lo_bank(lo_bank), .upper(upper), .mode(mode),
    .ram_en(ram_en)
  );

  cart_addr_map u_map (
    .addr_hi(bus_addr[15:13]), .rd_n(rd_n), .ram_cs_n(ram_cs_n),
    .lo_bank(lo_bank), .upper(upper), .mode(mode), .ram_en(ram_en),
    .rom_bank(rom_bank), .ram_bank(ram_bank), .rom_ce_n(rom_ce_n),
    .ram_ce_n(ram_ce_n)
  );
endmodule

// File: rtl/cart_bank_chk.sv
module cart_bank_chk (
  input logic        clk,
  input logic        rst_int_n,
  input logic [15:0] bus_addr,
  input logic        rd_n,
  input logic        wr_n,
  input logic        ram_cs_n,
  input logic [6:0]  rom_bank,
  input logic [1:0]  ram_bank,
  input logic        rom_ce_n,
  input logic        ram_ce_n,
  input logic [4:0]  lo_bank,
  input logic [1:0]  upper,
  input logic        mode,
  input logic        commit
);
  assert_low_window_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_addr[15:14] == 2'b00) |-> (rom_bank == 7'd0));

  assert_lo_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    lo_bank != 5'd0);

  assert_ram_bank_mode_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ram_bank != 2'd0) |-> (mode && ram_bank == upper));

  assert_ram_ce_window_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ram_ce_n |-> (!ram_cs_n && bus_addr[15:13] == 3'b101));

  assert_rom_ce_read_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rom_ce_n |-> (!rd_n && !bus_addr[15]));

  assert_no_commit_low_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !wr_n |-> !commit);

  assert_hold_regs_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !commit |=> ($stable(lo_bank) && $stable(upper) && $stable(mode)));
endmodule

bind cart_bank_ctrl cart_bank_chk u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .bus_addr(bus_addr), .rd_n(rd_n),
  .wr_n(wr_n), .ram_cs_n(ram_cs_n), .rom_bank(rom_bank), .ram_bank(ram_bank),
  .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .lo_bank(lo_bank), .upper(upper),
  .mode(mode), .commit(commit)
);

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_data;
  logic        rd_n, wr_n, ram_cs_n;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        rom_ce_n, ram_ce_n;

  int n_total = 0;
  int n_pass  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cart_bank_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .rd_n(rd_n), .wr_n(wr_n), .ram_cs_n(ram_cs_n), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n)
  );

  task automatic check(string req, int act, int exp);
    n_total++;
    if (act == exp) n_pass++;
    else $display("FAIL %s: actual %0d expected %0d", req, act, exp);
  endtask

  task automatic read_at(logic [15:0] a);
    @(negedge clk);
    bus_addr = a; rd_n = 1'b0; wr_n = 1'b1; ram_cs_n = 1'b1;
    #1;
  endtask

  task automatic ram_at(logic [15:0] a);
    @(negedge clk);
    bus_addr = a; rd_n = 1'b0; wr_n = 1'b1; ram_cs_n = 1'b0;
    #1;
  endtask

  // strobe low for two edges: first address, then final address
  task automatic bus_write(logic [15:0] a_first, logic [15:0] a_last, logic [7:0] d);
    @(negedge clk);
    rd_n = 1'b1; ram_cs_n = 1'b1; bus_addr = a_first; bus_data = d; wr_n = 1'b0;
    @(negedge clk);
    bus_addr = a_last;
    @(negedge clk);
    wr_n = 1'b1; bus_addr = 16'h0100;
    @(negedge clk);
  endtask

  task automatic t_reset();
    read_at(16'h4000);
    check("R1 reset low bank", rom_bank, 1);
    check("R8 rom_ce on read", rom_ce_n, 0);
    ram_at(16'hA000);
    check("R1 ram disabled", ram_ce_n, 1);
    check("R3 ram_bank mode0", ram_bank, 0);
  endtask

  task automatic t_bank_lo();
    bus_write(16'h2000, 16'h2000, 8'h13);
    read_at(16'h5FFF);
    check("R4 bank 0x13", rom_bank, 19);
    read_at(16'h3FFF);
    check("R2 lower window", rom_bank, 0);
    bus_write(16'h3000, 16'h3000, 8'h00);
    read_at(16'h4000);
    check("R4 zero to one", rom_bank, 1);
    bus_write(16'h2000, 16'h2000, 8'h20);
    read_at(16'h4000);
    check("R4 0x20 to one", rom_bank, 1);
    bus_write(16'h2000, 16'h2000, 8'hE5);
    read_at(16'h7000);
    check("R4 upper bits dropped", rom_bank, 5);
  endtask

  task automatic t_upper_mode0();
    bus_write(16'h4000, 16'h4000, 8'h02);
    read_at(16'h4000);
    check("R3 upper in rom", rom_bank, (2 << 5) | 5);
    read_at(16'h0000);
    check("R2 lower window mode0", rom_bank, 0);
    ram_at(16'hA000);
    check("R3 ram_bank zero", ram_bank, 0);
  endtask

  task automatic t_mode1();
    bus_write(16'h6000, 16'h6000, 8'h01);
    read_at(16'h4000);
    check("R6 rom top cleared", rom_bank, 5);
    read_at(16'h2000);
    check("R2 lower window mode1", rom_bank, 0);
    ram_at(16'hA000);
    check("R6 ram_bank upper", ram_bank, 2);
    bus_write(16'h6000, 16'h6000, 8'h00);
    read_at(16'h4000);
    check("R6 back to mode0", rom_bank, (2 << 5) | 5);
  endtask

  task automatic t_ram_enable();
    bus_write(16'h0000, 16'h0000, 8'h0A);
    ram_at(16'hA123);
    check("R5 enable", ram_ce_n, 0);
    ram_at(16'hC000);
    check("R7 outside window", ram_ce_n, 1);
    @(negedge clk);
    bus_addr = 16'hB000; ram_cs_n = 1'b1; #1;
    check("R7 cs high", ram_ce_n, 1);
    bus_write(16'h1000, 16'h1000, 8'h0B);
    ram_at(16'hA000);
    check("R5 disable", ram_ce_n, 1);
    bus_write(16'h1FFF, 16'h1FFF, 8'hFA);
    ram_at(16'hBFFF);
    check("R5 low nibble only", ram_ce_n, 0);
  endtask

  task automatic t_ignore();
    bus_write(16'hA000, 16'hA000, 8'h00);
    read_at(16'h4000);
    check("R9 a15 write ignored", rom_bank, (2 << 5) | 5);
    @(negedge clk);
    bus_addr = 16'h4000; rd_n = 1'b1; #1;
    check("R8 no read", rom_ce_n, 1);
    read_at(16'h8000);
    check("R8 high half", rom_ce_n, 1);
  endtask

  task automatic t_late_a15();
    bus_write(16'hA000, 16'h2000, 8'h07);
    read_at(16'h4000);
    check("R9 late a15 settles low", rom_bank, (2 << 5) | 7);
    bus_write(16'h2000, 16'hA000, 8'h09);
    read_at(16'h4000);
    check("R9 late a15 settles high", rom_bank, (2 << 5) | 7);
  endtask

  task automatic t_overlap();
    @(negedge clk);
    rd_n = 1'b1; ram_cs_n = 1'b1; bus_addr = 16'h6000; bus_data = 8'h01; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; bus_addr = 16'hA000; ram_cs_n = 1'b0; #1;
    check("R6 before commit", ram_bank, 0);
    @(negedge clk); #1;
    check("R6 after commit", ram_bank, 2);
    check("R7 ram enabled during commit", ram_ce_n, 0);
    bus_write(16'h6000, 16'h6000, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_data = '0;
    rd_n = 1'b1; wr_n = 1'b1; ram_cs_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_bank_lo();
    t_upper_mode0();
    t_mode1();
    t_ram_enable();
    t_ignore();
    t_late_a15();
    t_overlap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_pass, n_total);
      $finish;
    end
  end
endmodule